// File: doc/BRIEF.md
# Paged Program Counter Sequencer

This block produces the 12-bit instruction address for a 4K-word program store. The store is split into four pages of 1K words each. Every clock the surrounding core gives one decoded operation code. The code selects one of these actions: hold, step to the next word, jump or call, return, data write or add into the low byte of the PC, table add, hardware interrupt or software interrupt.

For jumps, calls and data writes, the two page-select bits from the status register supply the top two address bits. A return restores the full 12-bit address it saved, so the page-select bits have no effect on it. A five-entry return stack keeps the saved addresses. When a sixth push arrives, it overwrites the oldest entry, and the stack never flags an error.

The output is the address of the instruction currently being fetched.

Top module: `pc_seq`

## Requirements
- R1: While rst_ni is low, pc_o is 0xFFF and the return stack is empty. Every stack slot holds 0x000.
- R2: Op 1 (step) loads pc+1, and 0xFFF wraps to 0x000. Op 0 (hold) leaves pc_o unchanged. Codes 10 to 15 also leave pc_o unchanged.
- R3: Op 2 (jump) loads {page_i, lit_i}.
- R4: Op 3 (call) pushes pc+1 (12-bit wrap) and loads {page_i, lit_i}.
- R5: Op 4 (return) pops the top entry and loads all 12 bits of it into the PC. page_i is ignored.
- R6: Op 5 (data write) loads {page_i, 2'b00, acc_i}.
- R7: Op 6 (data add) loads {page_i, 2'b00, (pc[7:0]+acc_i) mod 256}. No carry reaches bit 8.
- R8: Op 7 (table add) loads {page_i, pc[9:8], (pc[7:0]+acc_i) mod 256}. Bits 9:8 are kept.
- R9: Op 8 (hardware interrupt) pushes the current pc unchanged and loads 0x001.
- R10: Op 9 (software interrupt) pushes pc+1 and loads 0x002.
- R11: The stack is last-in first-out with five slots. A sixth push overwrites the oldest slot. After any number of pushes, up to five pops return the five newest values, newest first.
- R12: A return with an empty stack leaves the stack pointer where it is. It loads the slot the most recent pop read, or 0x000 if no slot has been written since reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| op_i | input | 4 | Decoded sequencing operation |
| lit_i | input | 10 | Literal target within a page |
| acc_i | input | 8 | Accumulator value for writes and adds |
| page_i | input | 2 | Page-select bits from status |
| pc_o | output | 12 | Current program address |

## Verification
The bench targets the low-byte wrap on data add and table add. A design that let the carry into bit 8 through would land 256 words away. It also checks that bits 9:8 are cleared on data writes but kept on table add, since mixing these up sends computed jumps to the wrong quarter of the page. Stack overflow and empty pops are driven on purpose. A design that saturated instead of overwriting, or that moved the pointer on an empty pop, would return to stale or wrong addresses. Returns are issued with page_i set to a different page, so a design that injected the page bits on a return would be caught.

// File: rtl/pc_seq_pkg.sv
package pc_seq_pkg;
  typedef enum logic [3:0] {
    OP_HOLD = 4'd0,
    OP_INC  = 4'd1,
    OP_JMP  = 4'd2,
    OP_CALL = 4'd3,
    OP_RET  = 4'd4,
    OP_WR   = 4'd5,
    OP_ADD  = 4'd6,
    OP_TBL  = 4'd7,
    OP_HWI  = 4'd8,
    OP_SWI  = 4'd9
  } pc_op_e;
endpackage

// File: rtl/pc_ret_stack.sv
module pc_ret_stack #(
  parameter int PC_W  = 12,
  parameter int DEPTH = 5
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            push_i,
  input  logic            pop_i,
  input  logic [PC_W-1:0] push_data_i,
  output logic [PC_W-1:0] top_o
);
  localparam int SP_W  = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CNT_W = $clog2(DEPTH + 1);

  logic [PC_W-1:0]  mem_q [DEPTH];
  logic [SP_W-1:0]  sp_q, sp_inc, sp_dec, rd_idx;
  logic [CNT_W-1:0] cnt_q;
  logic             empty;

  assign empty  = (cnt_q == '0);
  assign sp_inc = (sp_q == SP_W'(DEPTH - 1)) ? '0 : sp_q + 1'b1;
  assign sp_dec = (sp_q == '0) ? SP_W'(DEPTH - 1) : sp_q - 1'b1;
  // empty pop re-reads the slot under the pointer
  assign rd_idx = empty ? sp_q : sp_dec;
  assign top_o  = mem_q[rd_idx];

  for (genvar g = 0; g < DEPTH; g++) begin : g_slot
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                             mem_q[g] <= '0;
      else if (push_i && sp_q == SP_W'(g))     mem_q[g] <= push_data_i;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sp_q  <= '0;
      cnt_q <= '0;
    end else if (push_i) begin
      sp_q <= sp_inc;
      if (cnt_q != CNT_W'(DEPTH)) cnt_q <= cnt_q + 1'b1;
    end else if (pop_i && !empty) begin
      sp_q  <= sp_dec;
      cnt_q <= cnt_q - 1'b1;
    end
  end

  AST_CNT_BOUND: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_q <= CNT_W'(DEPTH)); // R11
  AST_FULL_PUSH_SAT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    push_i && cnt_q == CNT_W'(DEPTH) |=> cnt_q == CNT_W'(DEPTH)); // R11
  AST_EMPTY_POP_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pop_i && !push_i && empty |=> $stable(sp_q) && cnt_q == '0); // R12
  AST_PUSH_POP_EXCL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(push_i && pop_i)); // R4
endmodule

// File: rtl/pc_next.sv
module pc_next
  import pc_seq_pkg::*;
#(
  parameter int PC_W  = 12,
  parameter int LIT_W = 10,
  parameter int ACC_W = 8,
  parameter logic [PC_W-1:0] HWI_VEC = 12'h001,
  parameter logic [PC_W-1:0] SWI_VEC = 12'h002
) (
  input  logic [3:0]            op_i,
  input  logic [PC_W-1:0]       pc_i,
  input  logic [LIT_W-1:0]      lit_i,
  input  logic [ACC_W-1:0]      acc_i,
  input  logic [PC_W-LIT_W-1:0] page_i,
  input  logic [PC_W-1:0]       top_i,
  output logic [PC_W-1:0]       next_o,
  output logic                  push_o,
  output logic                  pop_o,
  output logic [PC_W-1:0]       push_data_o
);
  localparam int MID_W = LIT_W - ACC_W;

  pc_op_e          op;
  logic [PC_W-1:0] pc_inc;
  logic [ACC_W-1:0] low_sum;

  assign op      = pc_op_e'(op_i);
  assign pc_inc  = pc_i + 1'b1;
  assign low_sum = pc_i[ACC_W-1:0] + acc_i;

  always_comb begin
    next_o      = pc_i;
    push_o      = 1'b0;
    pop_o       = 1'b0;
    push_data_o = pc_inc;
    unique case (op)
      OP_INC:  next_o = pc_inc;
      OP_JMP:  next_o = {page_i, lit_i};
      OP_CALL: begin
        next_o = {page_i, lit_i};
        push_o = 1'b1;
      end
      OP_RET: begin
        next_o = top_i;
        pop_o  = 1'b1;
      end
      OP_WR:   next_o = {page_i, {MID_W{1'b0}}, acc_i};
      OP_ADD:  next_o = {page_i, {MID_W{1'b0}}, low_sum};
      OP_TBL:  next_o = {page_i, pc_i[LIT_W-1:ACC_W], low_sum};
      OP_HWI: begin
        next_o      = HWI_VEC;
        push_o      = 1'b1;
        push_data_o = pc_i;
      end
      OP_SWI: begin
        next_o = SWI_VEC;
        push_o = 1'b1;
      end
      default: next_o = pc_i;
    endcase
  end
endmodule

// File: rtl/pc_seq.sv
module pc_seq
  import pc_seq_pkg::*;
#(
  parameter int PC_W  = 12,
  parameter int LIT_W = 10,
  parameter int ACC_W = 8,
  parameter int DEPTH = 5,
  parameter logic [PC_W-1:0] HWI_VEC = 12'h001,
  parameter logic [PC_W-1:0] SWI_VEC = 12'h002
) (
  input  logic                  clk_i,
  input  logic                  rst_ni,
  input  logic [3:0]            op_i,
  input  logic [LIT_W-1:0]      lit_i,
  input  logic [ACC_W-1:0]      acc_i,
  input  logic [PC_W-LIT_W-1:0] page_i,
  output logic [PC_W-1:0]       pc_o
);
  localparam int PAGE_W = PC_W - LIT_W;

  logic [PC_W-1:0] pc_q, pc_d, top, push_data;
  logic            push, pop;

  pc_next #(
    .PC_W(PC_W), .LIT_W(LIT_W), .ACC_W(ACC_W),
    .HWI_VEC(HWI_VEC), .SWI_VEC(SWI_VEC)
  ) u_next (
    .op_i(op_i), .pc_i(pc_q), .lit_i(lit_i), .acc_i(acc_i),
    .page_i(page_i), .top_i(top), .next_o(pc_d),
    .push_o(push), .pop_o(pop), .push_data_o(push_data)
  );

  pc_ret_stack #(.PC_W(PC_W), .DEPTH(DEPTH)) u_stack (
    .clk_i(clk_i), .rst_ni(rst_ni), .push_i(push), .pop_i(pop),
    .push_data_i(push_data), .top_o(top)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) pc_q <= '1;
    else         pc_q <= pc_d;
  end

  assign pc_o = pc_q;

  AST_HOLD_STABLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    op_i == OP_HOLD |=> $stable(pc_o)); // R2
  AST_JMP_TARGET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    op_i == OP_JMP |=> pc_o == {$past(page_i), $past(lit_i)}); // R3
  AST_WR_CLR_MID: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (op_i == OP_WR || op_i == OP_ADD) |=> pc_o[LIT_W-1:ACC_W] == '0); // R6
  AST_TBL_KEEP_MID: assert property (@(posedge clk_i) disable iff (!rst_ni)
    op_i == OP_TBL |=> pc_o[LIT_W-1:ACC_W] == $past(pc_o[LIT_W-1:ACC_W])); // R8
  AST_PAGE_INJECT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (op_i == OP_WR || op_i == OP_TBL) |=> pc_o[PC_W-1:PC_W-PAGE_W] == $past(page_i)); // R6
  AST_HWI_VEC: assert property (@(posedge clk_i) disable iff (!rst_ni)
    op_i == OP_HWI |=> pc_o == HWI_VEC); // R9
  AST_SWI_VEC: assert property (@(posedge clk_i) disable iff (!rst_ni)
    op_i == OP_SWI |=> pc_o == SWI_VEC); // R10
endmodule

// File: tb/pc_seq_test.sv
module pc_seq_test;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [3:0] op = 4'd0;
  logic [9:0] lit = '0;
  logic [7:0] acc = '0;
  logic [1:0] page = '0;
  logic [11:0] pc;

  int n_chk = 0, n_fail = 0;
  bit done = 0;

  int m_pc;
  int m_stk[5];
  int m_sp, m_cnt;

  always #5 clk = ~clk;

  pc_seq uut (.clk_i(clk), .rst_ni(rst_n), .op_i(op), .lit_i(lit),
              .acc_i(acc), .page_i(page), .pc_o(pc));

  function automatic void m_push(int v);
    m_stk[m_sp] = v & 12'hFFF;
    m_sp = (m_sp + 1) % 5;
    if (m_cnt < 5) m_cnt++;
  endfunction

  function automatic int m_pop();
    if (m_cnt > 0) begin
      m_sp = (m_sp + 4) % 5;
      m_cnt--;
    end
    return m_stk[m_sp];
  endfunction

  function automatic void m_step(int o, int l, int a, int p);
    case (o)
      1: m_pc = (m_pc + 1) & 12'hFFF;
      2: m_pc = (p << 10) | l;
      3: begin m_push(m_pc + 1); m_pc = (p << 10) | l; end
      4: m_pc = m_pop();
      5: m_pc = (p << 10) | a;
      6: m_pc = (p << 10) | ((m_pc + a) & 8'hFF);
      7: m_pc = (p << 10) | (m_pc & 12'h300) | ((m_pc + a) & 8'hFF);
      8: begin m_push(m_pc); m_pc = 1; end
      9: begin m_push(m_pc + 1); m_pc = 2; end
      default: ;
    endcase
  endfunction

  task automatic check(string req, int act, int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s pc=%03h expected %03h", req, act, exp);
    end
  endtask

  task automatic step(int o, int l, int a, int p, string req);
    @(negedge clk);
    op = 4'(o); lit = 10'(l); acc = 8'(a); page = 2'(p);
    m_step(o, l, a, p);
    @(posedge clk);
    #2;
    check(req, int'(pc), m_pc);
  endtask

  initial begin
    m_pc = 12'hFFF; m_sp = 0; m_cnt = 0;
    for (int i = 0; i < 5; i++) m_stk[i] = 0;
    #23;
    check("R1", int'(pc), 12'hFFF);
    @(negedge clk); rst_n = 1'b1;
    step(4, 0, 0, 3, "R12");          // empty pop after reset -> 0x000
    step(2, 12'h3FF, 0, 3, "R3");     // jump to 0xFFF
    step(1, 0, 0, 0, "R2");           // wrap to 0x000
    step(0, 0, 0, 1, "R2");
    step(12, 0, 0, 1, "R2");          // unused code holds
    step(2, 10'h155, 0, 2, "R3");
    step(1, 0, 0, 2, "R2");
    step(3, 10'h020, 0, 1, "R4");
    step(4, 0, 0, 3, "R5");           // page ignored on return
    // overflow: six calls, then six returns
    for (int i = 0; i < 6; i++) step(3, 10 * i + 3, 0, i % 4, "R11");
    for (int i = 0; i < 5; i++) step(4, 0, 0, 1, "R11");
    step(4, 0, 0, 2, "R12");          // empty again
    step(4, 0, 0, 2, "R12");
    step(2, 10'h3F0, 0, 1, "R3");     // pc=0x7F0
    step(6, 0, 8'h20, 1, "R7");       // wrap low byte, clear 9:8
    step(2, 10'h3F0, 0, 1, "R3");
    step(7, 0, 8'h25, 2, "R8");       // keep 9:8, wrap low byte
    step(5, 0, 8'hA5, 3, "R6");
    step(9, 0, 0, 0, "R10");
    step(8, 0, 0, 0, "R9");
    step(4, 0, 0, 1, "R9");           // returns to 0x002 itself
    step(4, 0, 0, 1, "R10");          // returns to write target + 1
    for (int i = 0; i < 400; i++)
      step(int'($urandom_range(0, 12)), int'($urandom_range(0, 1023)),
           int'($urandom_range(0, 255)), int'($urandom_range(0, 3)), "R11");
    done = 1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog expired");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end
endmodule